// File: doc/BRIEF.md
# Float to Signed Integer Converter

This block turns an unpacked floating-point operand into a signed two's-complement integer whose width is a parameter (32 or 64 bits). The operand arrives as a class code, a sign bit, a signed unbiased exponent and a left-aligned mantissa: the mantissa's top bit carries weight 2^exp, and each lower bit carries half the weight of the one above. The conversion always truncates toward zero; no rounding-mode input exists.

Any fraction bits lost in truncation raise an inexact flag. Values outside the representable range, and all infinities and NaNs, saturate to the largest or most negative integer. Saturation raises an invalid-conversion flag and clears inexact, and an overflow flag marks saturation caused by a finite value. The result and flags are registered, so they appear one clock after an operand is presented with its valid strobe.

Top module: `f2i_convert`

## Requirements
- R1: A zero-class operand (class code 0) yields integer 0 with inexact, invalid and overflow all clear.
- R2: A finite normal operand (class code 1) whose truncated magnitude is in range yields its integer part, truncated toward zero.
- R3: An in-range negative operand yields the two's-complement negation of its truncated magnitude.
- R4: For an in-range result, inexact is set exactly when at least one mantissa bit below the integer part is nonzero.
- R5: A negative exponent yields 0, with inexact set exactly when the mantissa is nonzero.
- R6: An exponent greater than or equal to the integer width N saturates, with invalid and overflow both set.
- R7: A finite magnitude saturates when it is at least 2^(N-1) for a positive sign, or above 2^(N-1) for a negative sign. A negative magnitude of exactly 2^(N-1) returns the most negative integer with no flag.
- R8: The saturated result is 2^(N-1)-1 for a positive sign and -2^(N-1) for a negative sign, and inexact is always clear when saturating.
- R9: Infinity (class code 2), quiet NaN (code 3) and signaling NaN (code 4) saturate by sign with invalid set and overflow clear.
- R10: Output valid follows input valid after exactly one clock. While reset is active, output valid, the result and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand present this cycle |
| inClass | input | 3 | Class code: 0 zero, 1 normal, 2 infinity, 3 quiet NaN, 4 signaling NaN |
| inSign | input | 1 | Operand sign, 1 = negative |
| inExp | input | EXP_W | Signed unbiased exponent |
| inMant | input | MANT_W | Mantissa; top bit has weight 2^inExp |
| outValid | output | 1 | Result valid |
| outInt | output | INT_W | Two's-complement result |
| outInexact | output | 1 | Fraction bits were discarded |
| outInvalid | output | 1 | Result saturated |
| outOverflow | output | 1 | Saturation caused by a finite value |

## Verification
The bench builds two instances side by side with a 64-bit mantissa: one with a 32-bit result and one with a 64-bit result, both fed the same operands. The 32-bit instance reaches the exponent-too-large path and the asymmetric boundary around 2^31 with moderate exponents. The 64-bit instance reaches a shift in which no fraction bit remains (exponent 63) and the boundary at 2^63, where the mantissa's top bit alone decides the outcome.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  typedef enum logic [2:0] {
    CLS_ZERO   = 3'd0,
    CLS_NORMAL = 3'd1,
    CLS_INF    = 3'd2,
    CLS_QNAN   = 3'd3,
    CLS_SNAN   = 3'd4
  } fclass_e;

  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic passZero;   // zero class: clean zero result
    logic special;    // inf / NaN: saturate, no overflow flag
    logic bigExp;     // exponent beyond integer width: saturate with overflow
    logic negExp;     // exponent below zero: shift everything out
    logic numeric;    // finite value that needs the range check
  } f2i_ctrl_t;
endpackage

// File: rtl/f2i_ctrl.sv
module f2i_ctrl
  import f2i_pkg::*;
#(
  parameter int INT_W = 32,
  parameter int EXP_W = 12
) (
  input  logic [2:0]             inClass,
  input  logic signed [EXP_W-1:0] inExp,
  output f2i_ctrl_t              strb
);
  localparam int EXP_LIMIT = INT_W;

  fclass_e cls;
  logic expTooBig;

  always_comb begin
    cls       = fclass_e'(inClass);
    expTooBig = int'(inExp) >= EXP_LIMIT;
    strb      = '0;
    unique case (cls)
      CLS_ZERO:   strb.passZero = 1'b1;
      CLS_NORMAL: begin
        strb.bigExp  = expTooBig;
        strb.negExp  = inExp < 0;
        strb.numeric = !expTooBig;
      end
      default:    strb.special = 1'b1;
    endcase
  end
endmodule

// File: rtl/f2i_datapath.sv
module f2i_datapath
  import f2i_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int EXP_W  = 12,
  parameter int MANT_W = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [2:0]              inClass,
  input  logic                    inSign,
  input  logic signed [EXP_W-1:0] inExp,
  input  logic [MANT_W-1:0]       inMant,
  input  f2i_ctrl_t               strb,
  output logic                    outValid,
  output logic [INT_W-1:0]        outInt,
  output logic                    outInexact,
  output logic                    outInvalid,
  output logic                    outOverflow
);
  localparam logic [INT_W-1:0] MIN_PAT = {1'b1, {(INT_W-1){1'b0}}};
  localparam logic [INT_W-1:0] MAX_PAT = ~MIN_PAT;

  int                 shAmt;
  logic [MANT_W-1:0]  shifted, lowMask;
  logic [INT_W-1:0]   magN;
  logic               sticky, magOvf, saturate;
  logic [INT_W-1:0]   nextInt;
  logic               nextInexact, nextInvalid, nextOverflow;

  // Alignment: integer part of the operand lands in the low bits
  always_comb begin
    if (strb.negExp || !strb.numeric) shAmt = MANT_W;
    else                              shAmt = MANT_W - 1 - int'(inExp);
    shifted = inMant >> shAmt;
    lowMask = ~({MANT_W{1'b1}} << shAmt);
    sticky  = |(inMant & lowMask);
    magN    = shifted[INT_W-1:0];
    magOvf  = {1'b0, magN} >= ({1'b0, MIN_PAT} + {{INT_W{1'b0}}, inSign});
  end

  // Result select
  always_comb begin
    saturate     = strb.special | strb.bigExp | (strb.numeric & magOvf);
    nextInt      = '0;
    nextInexact  = 1'b0;
    nextInvalid  = 1'b0;
    nextOverflow = 1'b0;
    if (strb.passZero) begin
      nextInt = '0;
    end else if (saturate) begin
      nextInt      = inSign ? MIN_PAT : MAX_PAT;
      nextInvalid  = 1'b1;
      nextOverflow = !strb.special;
    end else begin
      nextInt     = inSign ? (~magN + 1'b1) : magN;
      nextInexact = sticky;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      outInt      <= '0;
      outInexact  <= 1'b0;
      outInvalid  <= 1'b0;
      outOverflow <= 1'b0;
    end else begin
      outValid    <= inValid;
      outInt      <= nextInt;
      outInexact  <= nextInexact;
      outInvalid  <= nextInvalid;
      outOverflow <= nextOverflow;
    end
  end

  assert_valid_rise_R10: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  assert_valid_fall_R10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  assert_sat_value_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outInvalid) |-> ((outInt == MIN_PAT || outInt == MAX_PAT) && !outInexact));
  assert_overflow_invalid_R6: assert property (@(posedge clk) disable iff (!rstN)
    outOverflow |-> outInvalid);
  assert_zero_class_R1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inClass == 3'd0) |=> (outInt == '0 && !outInexact && !outInvalid && !outOverflow));
  assert_sign_R3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inClass == 3'd1 && inSign) |=> (outInvalid || outInt == '0 || outInt[INT_W-1]));
  assert_special_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inClass >= 3'd2 && inClass <= 3'd4) |=> (outInvalid && !outOverflow));
endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
  import f2i_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int EXP_W  = 12,
  parameter int MANT_W = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [2:0]              inClass,
  input  logic                    inSign,
  input  logic signed [EXP_W-1:0] inExp,
  input  logic [MANT_W-1:0]       inMant,
  output logic                    outValid,
  output logic [INT_W-1:0]        outInt,
  output logic                    outInexact,
  output logic                    outInvalid,
  output logic                    outOverflow
);
  f2i_ctrl_t strb;

  f2i_ctrl #(.INT_W(INT_W), .EXP_W(EXP_W)) u_ctrl (
    .inClass (inClass),
    .inExp   (inExp),
    .strb    (strb)
  );

  f2i_datapath #(.INT_W(INT_W), .EXP_W(EXP_W), .MANT_W(MANT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .inValid     (inValid),
    .inClass     (inClass),
    .inSign      (inSign),
    .inExp       (inExp),
    .inMant      (inMant),
    .strb        (strb),
    .outValid    (outValid),
    .outInt      (outInt),
    .outInexact  (outInexact),
    .outInvalid  (outInvalid),
    .outOverflow (outOverflow)
  );
endmodule

// File: tb/f2i_convert_bench.sv
module f2i_convert_bench;
  localparam int EXP_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [2:0] inClass = '0;
  logic inSign = 1'b0;
  logic signed [EXP_W-1:0] inExp = '0;
  logic [63:0] inMant = '0;

  logic        v32, x32, i32, o32;
  logic [31:0] r32;
  logic        v64, x64, i64, o64;
  logic [63:0] r64;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  f2i_convert #(.INT_W(32), .EXP_W(EXP_W), .MANT_W(64)) u_f2i_convert (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inClass(inClass), .inSign(inSign),
    .inExp(inExp), .inMant(inMant), .outValid(v32), .outInt(r32),
    .outInexact(x32), .outInvalid(i32), .outOverflow(o32));

  f2i_convert #(.INT_W(64), .EXP_W(EXP_W), .MANT_W(64)) u_f2i_convert_w64 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inClass(inClass), .inSign(inSign),
    .inExp(inExp), .inMant(inMant), .outValid(v64), .outInt(r64),
    .outInexact(x64), .outInvalid(i64), .outOverflow(o64));

  // Reference model written from the requirements
  function automatic void refConv(input logic [2:0] c, input logic s, input int e,
      input logic [63:0] m, input int n, output logic [63:0] r, output logic ix,
      output logic iv, output logic ov);
    logic [63:0] lim, maskN, mag;
    logic st;
    lim   = 64'd1 << (n - 1);
    maskN = (n == 64) ? '1 : ((64'd1 << n) - 1);
    r = '0; ix = 1'b0; iv = 1'b0; ov = 1'b0;
    if (c == 3'd0) return;
    if (c != 3'd1) begin
      iv = 1'b1; r = s ? lim : lim - 1; return;
    end
    if (e >= n) begin
      iv = 1'b1; ov = 1'b1; r = s ? lim : lim - 1; return;
    end
    if (e < 0) begin
      mag = '0; st = |m;
    end else begin
      mag = m >> (63 - e);
      st  = (e == 63) ? 1'b0 : ((m << (e + 1)) != 0);
    end
    if (mag >= lim + {63'd0, s}) begin
      iv = 1'b1; ov = 1'b1; r = s ? lim : lim - 1; return;
    end
    r  = s ? ((~mag + 1) & maskN) : mag;
    ix = st;
  endfunction

  task automatic check(input string tag, input int n, input logic gv, input logic [63:0] gr,
      input logic gx, input logic gi, input logic go, input logic [63:0] er,
      input logic ex, input logic ei, input logic eo);
    nChecks++;
    if (gv !== 1'b1 || gr !== er || gx !== ex || gi !== ei || go !== eo) begin
      nFails++;
      $display("FAIL %s w%0d: got v=%b int=%h ix=%b iv=%b ov=%b exp v=1 int=%h ix=%b iv=%b ov=%b",
               tag, n, gv, gr, gx, gi, go, er, ex, ei, eo);
    end
  endtask

  task automatic apply(input string tag, input logic [2:0] c, input logic s,
      input int e, input logic [63:0] m);
    logic [63:0] er32, er64;
    logic ex32, ei32, eo32, ex64, ei64, eo64;
    refConv(c, s, e, m, 32, er32, ex32, ei32, eo32);
    refConv(c, s, e, m, 64, er64, ex64, ei64, eo64);
    @(negedge clk);
    inValid = 1'b1; inClass = c; inSign = s; inExp = EXP_W'(e); inMant = m;
    @(negedge clk);
    inValid = 1'b0;
    check(tag, 32, v32, {32'd0, r32}, x32, i32, o32, er32, ex32, ei32, eo32);
    check(tag, 64, v64, r64, x64, i64, o64, er64, ex64, ei64, eo64);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("%0d/%0d checks passed", nChecks + 1 - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state
    nChecks++;
    if ({v32, r32, x32, i32, o32, v64, r64, x64, i64, o64} !== '0) begin
      nFails++;
      $display("FAIL R10 reset: got nonzero outputs exp all zero");
    end
    rstN = 1'b1;
    @(negedge clk);

    apply("R1 zero class", 3'd0, 1'b1, 5, 64'hFFFF_0000_0000_0001);
    apply("R2 one", 3'd1, 1'b0, 0, 64'h8000_0000_0000_0000);
    apply("R2 R4 2.5", 3'd1, 1'b0, 1, 64'hA000_0000_0000_0000);
    apply("R3 -2.5", 3'd1, 1'b1, 1, 64'hA000_0000_0000_0000);
    apply("R3 -6 exact", 3'd1, 1'b1, 2, 64'hC000_0000_0000_0000);
    apply("R4 all-ones fraction", 3'd1, 1'b0, 30, 64'hFFFF_FFFF_FFFF_FFFF);
    apply("R5 half", 3'd1, 1'b0, -1, 64'h8000_0000_0000_0000);
    apply("R5 tiny negative", 3'd1, 1'b1, -40, 64'h8000_0000_0000_0001);
    apply("R6 exp 32", 3'd1, 1'b0, 32, 64'h8000_0000_0000_0000);
    apply("R6 exp 70 neg", 3'd1, 1'b1, 70, 64'h8000_0000_0000_0000);
    apply("R7 pos 2^31", 3'd1, 1'b0, 31, 64'h8000_0000_0000_0000);
    apply("R7 neg 2^31", 3'd1, 1'b1, 31, 64'h8000_0000_0000_0000);
    apply("R7 neg 2^31 frac", 3'd1, 1'b1, 31, 64'h8000_0000_8000_0000);
    apply("R7 neg 1.5*2^31", 3'd1, 1'b1, 31, 64'hC000_0000_0000_0000);
    apply("R7 pos 2^63", 3'd1, 1'b0, 63, 64'h8000_0000_0000_0000);
    apply("R7 neg 2^63", 3'd1, 1'b1, 63, 64'h8000_0000_0000_0000);
    apply("R7 exp63 max", 3'd1, 1'b1, 62, 64'hFFFF_FFFF_FFFF_FFFF);
    apply("R8 sat with fraction", 3'd1, 1'b0, 40, 64'h8000_0000_0000_00FF);
    apply("R9 +inf", 3'd2, 1'b0, 0, 64'h0);
    apply("R9 -inf", 3'd2, 1'b1, 0, 64'h0);
    apply("R9 qnan", 3'd3, 1'b0, 0, 64'hC000_0000_0000_0000);
    apply("R9 snan", 3'd4, 1'b1, 0, 64'h8000_0000_0000_0001);

    // R10: no valid presented -> no valid out
    @(negedge clk);
    nChecks++;
    if (v32 !== 1'b0 || v64 !== 1'b0) begin
      nFails++;
      $display("FAIL R10 idle: got v32=%b v64=%b exp 0", v32, v64);
    end

    for (int k = 0; k < 600; k++) begin
      logic [2:0] c;
      logic [63:0] m;
      int e, sel;
      sel = $urandom_range(0, 9);
      c = (sel == 0) ? 3'd0 : (sel == 1) ? 3'd2 : (sel == 2) ? 3'd3 :
          (sel == 3) ? 3'd4 : 3'd1;
      e = int'($urandom_range(0, 85)) - 12;
      m = {1'b1, $urandom(), 31'($urandom())};
      if ($urandom_range(0, 1) == 1) m = m & ~((64'd1 << $urandom_range(0, 62)) - 1);
      apply("R2 R3 R4 R7 random", c, 1'($urandom()), e, m);
    end

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule